// File: doc/BRIEF.md
# CCD Line Readout Sequencer

This block paces a single line period of a full-frame CCD readout. Once a line is started, a counter advances once per pixel-rate enable. For the first part of the line the horizontal register clocks are kept stopped, because the image section is moving one row of charge into the output register during that time. When that window closes, the horizontal transport enable is raised and stays high until the end of the line. Each pixel shifted out in that part of the line is tagged with the kind of cell it came from.

The tag lets downstream logic do two things without counting on its own. It can clamp the analog chain on the optically shielded columns, and it can crop the frame to the image pixels. The vertical clock waveforms and the capture of pixel samples belong to neighbouring blocks. A one-cycle completion pulse marks the final period, so a frame controller can start the next line.

Top module: `ccd_line_seq`

## Requirements
- R1: During and right after reset, and whenever no line is running, `vxfer_win`, `hclk_run`, `pix_valid`, `clamp_win` and `line_done` are low and `pix_class` is 2'b00.
- R2: A line starts only when `line_start` and `pix_en` are both high at a clock edge while no line is running. The first line period (count 0) is then presented from the next cycle on. A `line_start` at any edge with `pix_en` low, or at any edge while a line is running (including its last period), has no effect on the outputs.
- R3: The line counter advances by one only at edges where `pix_en` is high. While `pix_en` is low, every output except `line_done` holds its value. A line lasts exactly 3487 enabled periods, counts 0 to 3486.
- R4: `vxfer_win` is high and `hclk_run` is low for counts 0 to 359, which is 360 periods.
- R5: `hclk_run` and `pix_valid` are high for counts 360 to 3486, so 3127 pixels are read out per line.
- R6: Readout pixel n = count − 360 is tagged in this fixed order, with codes 2'b00 dummy, 2'b01 black, 2'b10 timing and 2'b11 active. Pixels 0–6 are dummy, 7–26 black, 27–30 timing, 31–3102 active, 3103–3106 timing and 3107–3126 black.
- R7: While `pix_valid` is low, `pix_class` is 2'b00.
- R8: `clamp_win` is high exactly when `pix_valid` is high and `pix_class` is 2'b01. This covers both black segments.
- R9: `line_done` is high for exactly one cycle: the cycle in which count 3486 is presented and `pix_en` is high. At the following edge the line ends and all outputs return to the idle values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-rate enable; one line period per high cycle |
| line_start | input | 1 | Request to begin a line |
| vxfer_win | output | 1 | Row-transfer window; horizontal clocks stopped |
| hclk_run | output | 1 | Horizontal transport enable |
| clamp_win | output | 1 | Black-level clamp window |
| pix_valid | output | 1 | A readout pixel is being presented |
| pix_class | output | 2 | Pixel class: 00 dummy, 01 black, 10 timing, 11 active |
| line_done | output | 1 | Single-cycle last-period pulse |

## Verification
Two events can fall in the same cycle: the completion pulse and a new start request, since a controller running lines back to back wants to issue the next start at once. The bench holds `line_start` high across the final period of a line, in full-rate mode and with the enable gapped. The expectation is that the pulse appears once and the request is dropped: the next cycle must show the idle values, not a fresh row-transfer window. Start requests are also pulsed at the readout boundary and in mid-line, and raised while the enable is low. In every case the scoreboard must see the tag sequence run on undisturbed.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

   typedef enum logic [1:0] {
      CLS_DUMMY  = 2'b00,
      CLS_BLACK  = 2'b01,
      CLS_TIMING = 2'b10,
      CLS_ACTIVE = 2'b11
   } pix_class_e;

endpackage

// File: rtl/ccd_line_ctr.sv
module ccd_line_ctr #(
   parameter int LINE_LEN = 3487,
   parameter int CW       = $clog2(LINE_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_en,
   input  logic          line_start,
   output logic          busy,
   output logic [CW-1:0] cnt,
   output logic          last
);

   localparam logic [CW-1:0] LAST_CNT = CW'(LINE_LEN - 1);

   if (LINE_LEN < 2) begin : g_bad_len
      $error("ccd_line_ctr: LINE_LEN must be at least 2");
   end
   if ((2 ** CW) < LINE_LEN) begin : g_bad_cw
      $error("ccd_line_ctr: CW too narrow for LINE_LEN");
   end

   assign last = busy && (cnt == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         cnt <= '0;
         if (line_start && pix_en) begin
            busy <= 1'b1;
         end
      end else if (pix_en) begin
         if (cnt == LAST_CNT) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !pix_en |=> busy && $stable(cnt)); // R3

   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !(line_start && pix_en) |=> !busy); // R2

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      last && pix_en |=> !busy); // R9

endmodule

// File: rtl/ccd_line_window.sv
module ccd_line_window #(
   parameter int VXFER_LEN = 360,
   parameter int LINE_LEN  = 3487,
   parameter int CW        = $clog2(LINE_LEN),
   parameter int PW        = $clog2(LINE_LEN - VXFER_LEN + 1)
) (
   input  logic          busy,
   input  logic [CW-1:0] cnt,
   input  logic          last,
   input  logic          pix_en,
   output logic          vxfer_win,
   output logic          hclk_run,
   output logic          pix_valid,
   output logic [PW-1:0] pix_idx,
   output logic          line_done
);

   localparam logic [CW-1:0] RD_FIRST = CW'(VXFER_LEN);

   if (VXFER_LEN < 1 || VXFER_LEN >= LINE_LEN) begin : g_bad_win
      $error("ccd_line_window: VXFER_LEN must lie inside the line");
   end

   logic          in_read;
   logic [CW-1:0] rd_off;

   assign in_read   = busy && (cnt >= RD_FIRST);
   assign vxfer_win = busy && !in_read;
   assign hclk_run  = in_read;
   assign pix_valid = in_read;
   assign rd_off    = cnt - RD_FIRST;
   assign pix_idx   = in_read ? PW'(rd_off) : '0;
   assign line_done = last && pix_en;

endmodule

// File: rtl/ccd_class_dec.sv
module ccd_class_dec
   import ccd_seq_pkg::*;
#(
   parameter int N_DUMMY    = 7,
   parameter int N_BLACK_L  = 20,
   parameter int N_TIMING_L = 4,
   parameter int N_ACTIVE   = 3072,
   parameter int N_TIMING_R = 4,
   parameter int N_BLACK_R  = 20,
   parameter int PW         = 12
) (
   input  logic          valid,
   input  logic [PW-1:0] pix_idx,
   output pix_class_e    cls
);

   localparam int NSEG = 6;
   localparam int SEG_LEN [NSEG] = '{N_DUMMY, N_BLACK_L, N_TIMING_L,
                                     N_ACTIVE, N_TIMING_R, N_BLACK_R};
   localparam logic [1:0] SEG_CODE [NSEG] = '{CLS_DUMMY, CLS_BLACK, CLS_TIMING,
                                              CLS_ACTIVE, CLS_TIMING, CLS_BLACK};

   function automatic int seg_base(input int s);
      int acc;
      acc = 0;
      for (int j = 0; j < s; j++) acc += SEG_LEN[j];
      return acc;
   endfunction

   localparam int TOTAL = seg_base(NSEG);

   if (N_ACTIVE < 1) begin : g_bad_active
      $error("ccd_class_dec: N_ACTIVE must be positive");
   end
   if ((2 ** PW) <= TOTAL) begin : g_bad_pw
      $error("ccd_class_dec: PW too narrow for the pixel count");
   end

   logic [NSEG-1:0] hit;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam int LO = seg_base(g);
      localparam int HI = LO + SEG_LEN[g];
      assign hit[g] = (pix_idx >= PW'(LO)) && (pix_idx < PW'(HI));
   end

   always_comb begin
      cls = CLS_DUMMY;
      if (valid) begin
         for (int s = 0; s < NSEG; s++) begin
            if (hit[s]) cls = pix_class_e'(SEG_CODE[s]);
         end
      end
   end

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
   import ccd_seq_pkg::*;
#(
   parameter int VXFER_LEN  = 360,
   parameter int N_DUMMY    = 7,
   parameter int N_BLACK_L  = 20,
   parameter int N_TIMING_L = 4,
   parameter int N_ACTIVE   = 3072,
   parameter int N_TIMING_R = 4,
   parameter int N_BLACK_R  = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pix_en,
   input  logic       line_start,
   output logic       vxfer_win,
   output logic       hclk_run,
   output logic       clamp_win,
   output logic       pix_valid,
   output logic [1:0] pix_class,
   output logic       line_done
);

   localparam int PIX_PER_LINE = N_DUMMY + N_BLACK_L + N_TIMING_L + N_ACTIVE
                                 + N_TIMING_R + N_BLACK_R;
   localparam int LINE_LEN     = VXFER_LEN + PIX_PER_LINE;
   localparam int CW           = $clog2(LINE_LEN);
   localparam int PW           = $clog2(PIX_PER_LINE + 1);

   logic          busy;
   logic          last;
   logic [CW-1:0] cnt;
   logic [PW-1:0] pix_idx;
   pix_class_e    cls;

   ccd_line_ctr #(
      .LINE_LEN (LINE_LEN),
      .CW       (CW)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_en     (pix_en),
      .line_start (line_start),
      .busy       (busy),
      .cnt        (cnt),
      .last       (last)
   );

   ccd_line_window #(
      .VXFER_LEN (VXFER_LEN),
      .LINE_LEN  (LINE_LEN),
      .CW        (CW),
      .PW        (PW)
   ) u_win (
      .busy      (busy),
      .cnt       (cnt),
      .last      (last),
      .pix_en    (pix_en),
      .vxfer_win (vxfer_win),
      .hclk_run  (hclk_run),
      .pix_valid (pix_valid),
      .pix_idx   (pix_idx),
      .line_done (line_done)
   );

   ccd_class_dec #(
      .N_DUMMY    (N_DUMMY),
      .N_BLACK_L  (N_BLACK_L),
      .N_TIMING_L (N_TIMING_L),
      .N_ACTIVE   (N_ACTIVE),
      .N_TIMING_R (N_TIMING_R),
      .N_BLACK_R  (N_BLACK_R),
      .PW         (PW)
   ) u_dec (
      .valid   (pix_valid),
      .pix_idx (pix_idx),
      .cls     (cls)
   );

   assign pix_class = cls;
   assign clamp_win = pix_valid && (cls == CLS_BLACK);

   AST_READ_OPENS_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pix_valid) |-> pix_class == CLS_DUMMY); // R6

   AST_CLASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> pix_class == CLS_DUMMY); // R7

   AST_WIN_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vxfer_win) |-> hclk_run); // R5

   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> !vxfer_win && !hclk_run && !line_done); // R9

   AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      !vxfer_win && !hclk_run && line_start && pix_en |=> vxfer_win); // R2

endmodule

// File: tb/ccd_line_seq_tb.sv
module ccd_line_seq_tb;

   localparam int LINE = 3487;

   typedef struct packed {
      logic       vx;
      logic       ssc;
      logic       valid;
      logic [1:0] cls;
      logic       clamp;
      logic       done;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pix_en = 1'b0;
   logic       line_start = 1'b0;
   logic       vxfer_win, hclk_run, clamp_win, pix_valid, line_done;
   logic [1:0] pix_class;

   int   n_checks = 0;
   int   n_fails  = 0;
   int   en_mode  = 0;
   int   cyc      = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   ccd_line_seq u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_en     (pix_en),
      .line_start (line_start),
      .vxfer_win  (vxfer_win),
      .hclk_run   (hclk_run),
      .clamp_win  (clamp_win),
      .pix_valid  (pix_valid),
      .pix_class  (pix_class),
      .line_done  (line_done)
   );

   function automatic exp_t model(input int k);
      exp_t e;
      int   p;
      e    = '0;
      e.vx = (k < 360);
      p    = k - 360;
      if (!e.vx) begin
         e.ssc   = 1'b1;
         e.valid = 1'b1;
         if      (p < 7)    e.cls = 2'b00;
         else if (p < 27)   e.cls = 2'b01;
         else if (p < 31)   e.cls = 2'b10;
         else if (p < 3103) e.cls = 2'b11;
         else if (p < 3107) e.cls = 2'b10;
         else               e.cls = 2'b01;
      end
      e.clamp = e.valid && (e.cls == 2'b01);
      e.done  = (k == LINE - 1);
      return e;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
      end
   endtask

   // pixel-enable pattern: 0 full rate, 1 gapped, 2 held low
   initial begin
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         case (en_mode)
            0:       pix_en = 1'b1;
            1:       pix_en = (cyc % 3) != 0;
            default: pix_en = 1'b0;
         endcase
      end
   end

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() == 0) begin
            check("R1", "vxfer_win idle", vxfer_win, 0);
            check("R1", "hclk_run idle",  hclk_run,  0);
            check("R1", "pix_valid idle", pix_valid, 0);
            check("R7", "pix_class idle", pix_class, 0);
            check("R1", "clamp_win idle", clamp_win, 0);
            check("R9", "line_done idle", line_done, 0);
         end else begin
            exp_t e;
            e = q[0];
            check("R4", "vxfer_win",  vxfer_win, e.vx);
            check("R5", "hclk_run",   hclk_run,  e.ssc);
            check("R5", "pix_valid",  pix_valid, e.valid);
            check("R6", "pix_class",  pix_class, e.cls);
            check("R8", "clamp_win",  clamp_win, e.clamp);
            check("R9", "line_done",  line_done, e.done && pix_en);
            if (pix_en) void'(q.pop_front()); // R3: advance only when enabled
         end
      end
   end

   // driver: starts a line, pushes its expected periods, pokes line_start
   task automatic run_line();
      bit acc;
      @(posedge clk);
      #1 line_start = 1'b1;
      acc = 1'b0;
      while (!acc) begin
         @(posedge clk);
         acc = pix_en;
         #1;
      end
      line_start = 1'b0;
      for (int k = 0; k < LINE; k++) q.push_back(model(k)); // R2 accepted start
      // R2: start requests inside a running line are dropped
      wait (q.size() == 3127);
      @(posedge clk); #1 line_start = 1'b1;
      @(posedge clk); #1 line_start = 1'b0;
      wait (q.size() == 1500);
      @(posedge clk); #1 line_start = 1'b1;
      repeat (3) @(posedge clk);
      #1 line_start = 1'b0;
      // R9: request coinciding with the done pulse must not restart
      wait (q.size() == 1);
      @(posedge clk); #1 line_start = 1'b1;
      while (q.size() != 0) begin
         @(posedge clk); #1;
      end
      line_start = 1'b0;
      repeat (4) @(posedge clk);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;                     // R1 checked by monitor during reset
      repeat (3) @(posedge clk);
      en_mode = 0;
      run_line();                           // full rate
      en_mode = 1;
      run_line();                           // R3 gapped enable
      en_mode = 2;
      @(posedge clk); #1 line_start = 1'b1; // R2 start with enable low ignored
      repeat (12) @(posedge clk);
      #1 line_start = 1'b0;
      repeat (3) @(posedge clk);
      en_mode = 0;
      run_line();
      run_line();                           // back to back
      #1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired, queue %0d", q.size());
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule